// File: doc/BRIEF.md
# Dual-Channel Capture/Compare Timer

A timer block built around a 16-bit free-running counter. The counter advances on a prescaled tick chosen by a 3-bit clock-select field, and a run bit starts and stops it. Software can read the counter or load it at any moment, including while it counts. A compare unit emits a one-cycle match pulse each time the counter steps onto the value held in the compare register. Two independent capture channels watch an input pin each, and on a selected edge they copy the counter value into a capture register and set a sticky flag that only software clears. Each channel's interrupt output is its flag gated by an enable bit.

The block does nothing until an unlock key has been written. It is programmed through a simple register bus: a write strobe, a 3-bit address, write data and combinational read data. Register map (address: content): 0 unlock key (read: bit 0 = unlocked), 1 counter control, 2 counter, 3 compare, 4 channel configuration, 5 interrupt flags and enables, 6 channel 0 capture, 7 channel 1 capture.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset the block is locked: the counter does not advance, no match pulse occurs and no capture happens. Writing 0x55 to bits 7:0 at address 0 unlocks the block permanently. Any other value leaves it locked. Register writes are accepted while locked.
- R2: The counter at address 2 is 16 bits. A write loads any value, wins over a tick in the same cycle, and counting continues from the loaded value.
- R3: In the control register at address 1, bit 3 is the run bit. While it is 0 the counter holds its value.
- R4: Control bits 2:0 hold a code n (0..7) that gives one count step every 2^n clocks. The prescaler restarts when run goes from 0 to 1, so the first step comes 2^n clocks after the enabling write.
- R5: The match output is high for exactly one cycle, in the cycle after the counter steps onto the value of the compare register at address 3. A software load of the counter never causes a match.
- R6: In the channel configuration at address 4, bits 1:0 select channel 0's edge and bits 3:2 select channel 1's edge (00 none, 01 rising, 10 falling, 11 both). Bit 4 puts channel 0 in capture mode and bit 5 does the same for channel 1. A channel with capture mode clear or edge code 00 never captures.
- R7: Each pin passes through a two-flop synchronizer. On a selected edge the channel copies the counter into its capture register (address 6 for channel 0, 7 for channel 1). This happens on the third clock edge after the pin changes. Capture works whether or not the counter is running.
- R8: A capture sets the channel's flag (bit 0 for channel 0, bit 1 for channel 1, at address 5). Only a bus write of 0 to that bit clears it. Writing 1 leaves the flag unchanged. A capture in the same cycle as a clear wins.
- R9: Bits 2 and 3 at address 5 enable channels 0 and 1. Each irq_o bit equals that channel's flag ANDed with its enable.
- R10: The counter wraps from 0xFFFF to 0x0000 and keeps counting.
- R11: When a counter write and a capture fall in the same cycle, the capture register receives the counter value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| cap_pin_i | input | 2 | Capture input pins, bit i for channel i |
| match_o | output | 1 | One-cycle compare-match pulse |
| irq_o | output | 2 | Per-channel interrupt (flag AND enable) |

## Verification
The bench attacks the lock gate first: a key of 0x54 must not start the counter, and a design that checked fewer bits or treated any write as a key would count and pulse the match output early. It times the prescaler at code 2, where an off-by-one divider or one not restarted on run shows up as a wrong count after 9 and 12 clocks. It drives edges of the wrong polarity, edge code 00 and a cleared capture-mode bit, where a loose edge decoder would raise flags. It lands a counter write on the exact capture cycle, where a design that latched the post-write value would report 0x9999 instead of 0x1234. Match pulses are scored by cycle number, including one across the 0xFFFF wrap, so a level-style match or a missed wrap is caught.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int CLK_SEL_W = 3;

    typedef enum logic [2:0] {
        A_KEY   = 3'd0,
        A_CTRL  = 3'd1,
        A_COUNT = 3'd2,
        A_CMP   = 3'd3,
        A_CHCFG = 3'd4,
        A_IRQ   = 3'd5,
        A_CAP0  = 3'd6,
        A_CAP1  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic                 run;
        logic [CLK_SEL_W-1:0] clk_sel;
    } ctrl_t;

    function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
        case (sel)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_ANY:  edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cct_prescale.sv
module cct_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask   = (DIV_W'(1) << sel_i) - DIV_W'(1);
        tick_o = run_i && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // R4: the divider is back at zero in the first running cycle
    assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(run_i) |-> (div_q == '0));

endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             stepped_o
);
    logic [CNT_W-1:0] count_q;
    logic             stepped_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            stepped_q <= 1'b0;
        end else if (wr_i) begin
            count_q   <= wdata_i;
            stepped_q <= 1'b0;
        end else if (tick_i) begin
            count_q   <= count_q + CNT_W'(1);
            stepped_q <= 1'b1;
        end else begin
            stepped_q <= 1'b0;
        end
    end

    assign count_o   = count_q;
    assign stepped_o = stepped_q;

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !wr_i) |=> $stable(count_q));

    assert_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !wr_i && (count_q == {CNT_W{1'b1}})) |=> (count_q == '0));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (count_q == $past(wdata_i)));

endmodule

// File: rtl/cct_capture.sv
module cct_capture
    import cct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             pin_i,
    input  edge_sel_e        edge_i,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o
);
    logic [2:0]       sync_q;
    logic             rise;
    logic             fall;
    logic             hit;
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;

    always_comb begin
        rise = sync_q[1] & ~sync_q[2];
        fall = ~sync_q[1] & sync_q[2];
        hit  = enable_i && mode_i && edge_hit(edge_i, rise, fall);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[1:0], pin_i};
            if (hit) begin
                cap_q <= count_i;
            end
            if (hit) begin
                flag_q <= 1'b1;
            end else if (clr_i) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign cap_o  = cap_q;
    assign flag_o = flag_q;

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);

    assert_capture_old_value_R11: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cap_q == $past(count_i)));

    assert_no_capture_off_R6: assert property (@(posedge clk) disable iff (rst)
        (!mode_i || edge_i == EDGE_OFF) |=> $stable(cap_q));

endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
    import cct_pkg::*;
#(
    parameter int          CNT_W      = 16,
    parameter int          N_CH       = 2,
    parameter logic [7:0]  UNLOCK_KEY = 8'h55
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]  cap_pin_i,
    output logic             match_o,
    output logic [N_CH-1:0]  irq_o
);
    localparam int MODE_LSB = 2 * N_CH;
    localparam int EN_LSB   = N_CH;

    reg_addr_e        addr;
    logic             unlocked_q;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_q;
    edge_sel_e        edge_q [N_CH];
    logic [N_CH-1:0]  mode_q;
    logic [N_CH-1:0]  en_q;
    logic [N_CH-1:0]  flag;
    logic [N_CH-1:0]  clr;
    logic [CNT_W-1:0] cap_val [N_CH];

    logic             tick;
    logic             cnt_wr;
    logic [CNT_W-1:0] count;
    logic             stepped;

    assign addr   = reg_addr_e'(bus_addr);
    assign cnt_wr = bus_wr && (addr == A_COUNT);

    // Register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked_q <= 1'b0;
            ctrl_q     <= '0;
            cmp_q      <= '0;
            mode_q     <= '0;
            en_q       <= '0;
            for (int i = 0; i < N_CH; i++) edge_q[i] <= EDGE_OFF;
        end else if (bus_wr) begin
            case (addr)
                A_KEY:   if (bus_wdata[7:0] == UNLOCK_KEY) unlocked_q <= 1'b1;
                A_CTRL:  ctrl_q <= bus_wdata[CLK_SEL_W:0];
                A_CMP:   cmp_q  <= bus_wdata;
                A_CHCFG: begin
                    for (int i = 0; i < N_CH; i++) begin
                        edge_q[i] <= edge_sel_e'(bus_wdata[2*i +: 2]);
                        mode_q[i] <= bus_wdata[MODE_LSB + i];
                    end
                end
                A_IRQ:   en_q <= bus_wdata[EN_LSB +: N_CH];
                default: ;
            endcase
        end
    end

    // Flag clear: a 0 written to a flag bit
    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            clr[i] = bus_wr && (addr == A_IRQ) && !bus_wdata[i];
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (addr)
            A_KEY:   bus_rdata[0] = unlocked_q;
            A_CTRL:  bus_rdata[CLK_SEL_W:0] = ctrl_q;
            A_COUNT: bus_rdata = count;
            A_CMP:   bus_rdata = cmp_q;
            A_CHCFG: begin
                for (int i = 0; i < N_CH; i++) begin
                    bus_rdata[2*i +: 2]      = edge_q[i];
                    bus_rdata[MODE_LSB + i]  = mode_q[i];
                end
            end
            A_IRQ: begin
                bus_rdata[0 +: N_CH]      = flag;
                bus_rdata[EN_LSB +: N_CH] = en_q;
            end
            default: begin
                for (int i = 0; i < N_CH; i++) begin
                    if (bus_addr == 3'(A_CAP0 + i)) bus_rdata = cap_val[i];
                end
            end
        endcase
    end

    cct_prescale #(.SEL_W(CLK_SEL_W)) u_prescale (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ctrl_q.run && unlocked_q),
        .sel_i  (ctrl_q.clk_sel),
        .tick_o (tick)
    );

    cct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .wr_i      (cnt_wr),
        .wdata_i   (bus_wdata),
        .count_o   (count),
        .stepped_o (stepped)
    );

    assign match_o = unlocked_q && stepped && (count == cmp_q);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        cct_capture #(.CNT_W(CNT_W)) u_cap (
            .clk      (clk),
            .rst      (rst),
            .enable_i (unlocked_q),
            .pin_i    (cap_pin_i[g]),
            .edge_i   (edge_q[g]),
            .mode_i   (mode_q[g]),
            .count_i  (count),
            .clr_i    (clr[g]),
            .cap_o    (cap_val[g]),
            .flag_o   (flag[g])
        );
    end

    assign irq_o = flag & en_q;

    assert_locked_no_tick_R1: assert property (@(posedge clk) disable iff (rst)
        !unlocked_q |-> !tick);

    assert_locked_no_flag_R1: assert property (@(posedge clk) disable iff (rst)
        !unlocked_q |-> (flag == '0));

    assert_single_match_R5: assert property (@(posedge clk) disable iff (rst)
        match_o |=> !match_o);

    assert_unlock_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        unlocked_q |=> unlocked_q);

endmodule

// File: tb/cap_cmp_timer_bench.sv
module cap_cmp_timer_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [1:0]  cap_pin_i;
    logic        match_o;
    logic [1:0]  irq_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int match_q[$];
    logic [15:0] rv;

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    cap_cmp_timer u_cap_cmp_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_pin_i (cap_pin_i),
        .match_o   (match_o),
        .irq_o     (irq_o)
    );

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    task automatic pin(int ch, logic v);
        @(negedge clk);
        cap_pin_i[ch] = v;
        repeat (4) @(posedge clk);
    endtask

    // Monitor: match pulses are scored against expected cycle numbers (R5)
    always @(negedge clk) begin
        if (!rst && match_o) begin
            checks++;
            if (match_q.size() == 0) begin
                fails++;
                $display("FAIL R5: unexpected match at cycle %0d expected none", cyc);
            end else begin
                int e;
                e = match_q.pop_front();
                if (e != cyc) begin
                    fails++;
                    $display("FAIL R5: match at cycle %0d expected %0d", cyc, e);
                end
            end
        end
    end

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; cap_pin_i = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // Reset state
        rd(3'd1, rv); check("R3 reset ctrl", rv, 16'h0);
        rd(3'd2, rv); check("R2 reset count", rv, 16'h0);
        rd(3'd0, rv); check("R1 reset locked", rv, 16'h0);
        check("R9 reset irq", {14'b0, irq_o}, 16'h0);

        // Locked: nothing moves (R1)
        wr(3'd2, 16'd10);
        wr(3'd3, 16'd12);
        wr(3'd4, 16'h0039);
        wr(3'd1, 16'h0008);
        repeat (20) @(posedge clk);
        rd(3'd2, rv); check("R1 locked count holds", rv, 16'd10);
        pin(0, 1'b1);
        rd(3'd5, rv); check("R1 locked no capture", rv & 16'h3, 16'h0);
        wr(3'd0, 16'h0054);
        repeat (10) @(posedge clk);
        rd(3'd2, rv); check("R1 wrong key stays locked", rv, 16'd10);
        rd(3'd0, rv); check("R1 wrong key status", rv, 16'h0);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0055);
        rd(3'd0, rv); check("R1 unlocked status", rv, 16'h1);
        pin(0, 1'b0);

        // Compare match (R5) and full-speed counting
        wr(3'd2, 16'h0FFB);
        wr(3'd3, 16'h1000);
        wr(3'd1, 16'h0008);
        match_q.push_back(cyc + 5);
        repeat (7) @(posedge clk);
        rd(3'd2, rv); check("R4 sel0 counts every clock", rv, 16'h1002);
        wr(3'd1, 16'h0000);
        rd(3'd2, rv);
        repeat (10) @(posedge clk);
        begin
            logic [15:0] v2;
            rd(3'd2, v2); check("R3 stopped counter holds", v2, rv);
        end

        // Wrap (R10) with a match just after it
        wr(3'd2, 16'hFFFE);
        wr(3'd3, 16'h0001);
        wr(3'd1, 16'h0008);
        match_q.push_back(cyc + 3);
        repeat (2) @(posedge clk);
        rd(3'd2, rv); check("R10 wrap to zero", rv, 16'h0000);

        // Write while running (R2)
        wr(3'd2, 16'h0050);
        repeat (3) @(posedge clk);
        rd(3'd2, rv); check("R2 write while running", rv, 16'h0053);
        wr(3'd1, 16'h0000);

        // Loading the compare value does not match (R5)
        wr(3'd3, 16'h0777);
        wr(3'd2, 16'h0777);
        repeat (3) @(posedge clk);

        // Prescaler code 2 (R4)
        wr(3'd2, 16'h0000);
        wr(3'd1, 16'h000A);
        repeat (9) @(posedge clk);
        rd(3'd2, rv); check("R4 sel2 after 9 clocks", rv, 16'd2);
        repeat (3) @(posedge clk);
        rd(3'd2, rv); check("R4 sel2 after 12 clocks", rv, 16'd3);
        wr(3'd1, 16'h0000);

        // Captures: ch0 rising, ch1 falling, both modes on (R6, R7)
        wr(3'd4, 16'h0039);
        wr(3'd5, 16'h0004);
        wr(3'd2, 16'h0AAA);
        pin(0, 1'b1);
        rd(3'd6, rv); check("R7 ch0 rising capture", rv, 16'h0AAA);
        rd(3'd5, rv); check("R8 ch0 flag set", rv & 16'h3, 16'h1);
        check("R9 irq ch0 enabled", {14'b0, irq_o}, 16'h1);
        pin(1, 1'b1);
        rd(3'd5, rv); check("R6 ch1 ignores rising", rv & 16'h3, 16'h1);
        wr(3'd2, 16'h0BBB);
        pin(1, 1'b0);
        rd(3'd7, rv); check("R7 ch1 falling capture", rv, 16'h0BBB);
        check("R9 irq ch1 masked", {14'b0, irq_o}, 16'h1);
        wr(3'd5, 16'h000F);
        rd(3'd5, rv); check("R8 writing 1 keeps flags", rv, 16'h000F);
        check("R9 irq both enabled", {14'b0, irq_o}, 16'h3);
        wr(3'd5, 16'h000E);
        rd(3'd5, rv); check("R8 writing 0 clears flag0", rv, 16'h000E);
        check("R9 irq after clear", {14'b0, irq_o}, 16'h2);
        pin(0, 1'b0);
        rd(3'd5, rv); check("R6 ch0 ignores falling", rv & 16'h1, 16'h0);

        // Both edges on ch0 (R6)
        wr(3'd4, 16'h003B);
        wr(3'd2, 16'h0CCC);
        pin(0, 1'b1);
        rd(3'd6, rv); check("R6 both edges rising", rv, 16'h0CCC);
        wr(3'd2, 16'h0CCD);
        pin(0, 1'b0);
        rd(3'd6, rv); check("R6 both edges falling", rv, 16'h0CCD);

        // Capture mode off (R6)
        wr(3'd4, 16'h000B);
        wr(3'd5, 16'h000C);
        wr(3'd2, 16'h0DDD);
        pin(0, 1'b1);
        rd(3'd5, rv); check("R6 mode off no flag", rv & 16'h3, 16'h0);
        rd(3'd6, rv); check("R6 mode off cap unchanged", rv, 16'h0CCD);

        // Edge code 00 (R6)
        wr(3'd4, 16'h0030);
        pin(0, 1'b0);
        rd(3'd5, rv); check("R6 code 00 no flag", rv & 16'h3, 16'h0);

        // Write and capture in the same cycle (R11)
        wr(3'd4, 16'h0039);
        wr(3'd2, 16'h1234);
        @(negedge clk);
        cap_pin_i[0] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        wr(3'd2, 16'h9999);
        repeat (2) @(posedge clk);
        rd(3'd6, rv); check("R11 capture keeps old count", rv, 16'h1234);
        rd(3'd2, rv); check("R11 counter took write", rv, 16'h9999);

        repeat (5) @(posedge clk);
        check("R5 all expected matches seen", 16'(match_q.size()), 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule